// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block tracks insertion and removal of devices on up to 32 expansion slots. It keeps three masks: slots that hold a device, slots that may be hot-swapped, and removals still waiting for the operating system to act. Insert and remove events arrive one at a time and carry a slot number and a boot-time flag. A boot-time insert only records the device. Any other event also sends a one-cycle pulse toward the general-purpose event status logic, which decides whether to raise the system control interrupt.

Software sees a window of four 32-bit words. The first word is a re-check mask, built on the fly as present AND hot-swappable. The second word holds the pending removals. The third word is the eject command and reads as zero. The fourth word is the hot-swappable mask. A write of the eject word services only the lowest set bit. That slot's pending bit is cleared. The teardown is then handed to an external slot agent through a request/acknowledge handshake. The agent answers whether the slot is now empty, and the present bit is cleared only if it is.

A system reset request first ejects every pending removal, lowest slot first, through the same agent. It then rebuilds the masks: hot-swappable becomes every slot except the fixed ones, and present is copied from the occupancy input. The same rebuild runs one cycle after the hardware reset is released.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A 32-bit read (reg_req=1, reg_we=0, reg_size32=1) at offset 0x0 returns present AND hot-swappable, combinationally. A read that is not 32-bit returns zero.
- R2: A 32-bit read at 0x4 returns the pending-removal mask. A read at 0x8 returns zero. A read at 0xC returns the hot-swappable mask. Any other offset reads zero.
- R3: A write to 0x0, 0x4 or 0xC has no effect, and so does any write that is not 32-bit.
- R4: An insert event (evt_insert=1) with evt_cold=1 sets the slot's present bit at the next edge and gives no gpe_hp pulse.
- R5: An insert event with evt_cold=0 sets the present bit and drives gpe_hp high for exactly the one cycle after the event edge.
- R6: A remove event (evt_insert=0) sets the slot's pending bit and gives the same one-cycle gpe_hp pulse. The present bit is not changed.
- R7: A nonzero 32-bit write to 0x8 while idle picks the lowest set bit of the data as the slot. At the next edge it clears that pending bit, raises agent_req with agent_slot, and holds both steady until the edge where agent_ack=1.
- R8: At the acknowledge edge the present bit of the serviced slot is cleared if agent_free=1 and kept if agent_free=0.
- R9: An eject write of zero has no effect. So does an eject write while busy=1.
- R10: A sys_reset pulse while idle ejects every pending removal through the agent, lowest slot first. When none remain it sets hot-swappable to ~fixed_mask and present to occupied. busy stays high throughout.
- R11: While rst_n is low all masks read zero and busy=1. One cycle after release, hot-swappable equals ~fixed_mask, present equals occupied and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_size32 | input | 1 | Access is a full 32-bit word |
| reg_addr | input | 4 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_valid | input | 1 | Slot event strobe |
| evt_slot | input | 5 | Slot number of the event |
| evt_insert | input | 1 | 1 = insert, 0 = remove |
| evt_cold | input | 1 | Insert happened at boot, no notification |
| gpe_hp | output | 1 | One-cycle hot-plug status pulse |
| agent_req | output | 1 | Teardown request to the slot agent |
| agent_slot | output | 5 | Slot being torn down |
| agent_ack | input | 1 | Agent finished the request |
| agent_free | input | 1 | Slot is now empty (valid with ack) |
| occupied | input | 32 | Slots currently holding a device |
| fixed_mask | input | 32 | Slots whose device cannot be hot-swapped |
| sys_reset | input | 1 | Request drain and rebuild |
| busy | output | 1 | Eject, drain or rebuild in progress |

## Verification
The bench sends eject words with several bits set, to catch a design that picks the highest slot or services more than one. It also sends an eject of zero, which a careless decoder would turn into a request for slot 0. An agent answer of "not free" must leave the device marked present, and writes to the read-only words must leave every mask untouched. The reset drain is run with three removals outstanding. A design that cleared them all at once, skipped the agent, or rebuilt before the drain finished would show a different sequence of agent_slot values or wrong masks afterwards.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } hp_state_e;

  localparam logic [3:0] OFS_UP  = 4'h0;
  localparam logic [3:0] OFS_DN  = 4'h4;
  localparam logic [3:0] OFS_EJ  = 4'h8;
  localparam logic [3:0] OFS_RMV = 4'hC;
endpackage

// File: rtl/hp_prio_enc.sv
module hp_prio_enc #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
  import hp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         rd_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] present,
  input  logic [W-1:0] hp_en,
  input  logic [W-1:0] pend,
  output logic [W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_UP:  rdata = present & hp_en;
        OFS_DN:  rdata = pend;
        OFS_RMV: rdata = hp_en;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/hp_seq_fsm.sv
module hp_seq_fsm
  import hp_pkg::*;
#(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_reset,
  input  logic          eject_go,
  input  logic [IW-1:0] eject_idx,
  input  logic          pend_any,
  input  logic [IW-1:0] pend_idx,
  input  logic          agent_ack,
  input  logic          agent_free,
  output logic          busy,
  output logic          agent_req,
  output logic [IW-1:0] slot_q,
  output logic          clr_pend,
  output logic          clr_present,
  output logic          rebuild
);
  hp_state_e     state_q, state_n;
  logic          drain_q, drain_n;
  logic [IW-1:0] slot_n;

  always_comb begin
    state_n     = state_q;
    drain_n     = drain_q;
    slot_n      = slot_q;
    clr_pend    = 1'b0;
    clr_present = 1'b0;
    rebuild     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sys_reset) begin
          state_n = ST_DRAIN;
        end else if (eject_go) begin
          state_n  = ST_WAIT;
          slot_n   = eject_idx;
          clr_pend = 1'b1;
          drain_n  = 1'b0;
        end
      end
      ST_WAIT: begin
        if (agent_ack) begin
          clr_present = agent_free;
          state_n     = drain_q ? ST_DRAIN : ST_IDLE;
        end
      end
      ST_DRAIN: begin
        if (pend_any) begin
          state_n  = ST_WAIT;
          slot_n   = pend_idx;
          clr_pend = 1'b1;
          drain_n  = 1'b1;
        end else begin
          rebuild = 1'b1;
          drain_n = 1'b0;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DRAIN;
      drain_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      state_q <= state_n;
      drain_q <= drain_n;
      slot_q  <= slot_n;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign agent_req = (state_q == ST_WAIT);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic                 reg_size32,
  input  logic [3:0]           reg_addr,
  input  logic [NUM_SLOTS-1:0] reg_wdata,
  output logic [NUM_SLOTS-1:0] reg_rdata,
  input  logic                 evt_valid,
  input  logic [SW-1:0]        evt_slot,
  input  logic                 evt_insert,
  input  logic                 evt_cold,
  output logic                 gpe_hp,
  output logic                 agent_req,
  output logic [SW-1:0]        agent_slot,
  input  logic                 agent_ack,
  input  logic                 agent_free,
  input  logic [NUM_SLOTS-1:0] occupied,
  input  logic [NUM_SLOTS-1:0] fixed_mask,
  input  logic                 sys_reset,
  output logic                 busy
);
  logic [NUM_SLOTS-1:0] present_q, present_n;
  logic [NUM_SLOTS-1:0] hp_en_q, hp_en_n;
  logic [NUM_SLOTS-1:0] down_q, down_n;
  logic                 gpe_n;

  logic [SW-1:0] ej_idx, pd_idx, clr_idx;
  logic          ej_any, pd_any;
  logic          clr_pend, clr_present, rebuild;
  logic          eject_wr, rd_en;

  assign eject_wr = reg_req & reg_we & reg_size32 & (reg_addr == OFS_EJ) & ej_any;
  assign rd_en    = reg_req & ~reg_we & reg_size32;

  hp_prio_enc #(.W(NUM_SLOTS)) ej_enc_i (.vec(reg_wdata), .idx(ej_idx), .any(ej_any));
  hp_prio_enc #(.W(NUM_SLOTS)) pd_enc_i (.vec(down_q),    .idx(pd_idx), .any(pd_any));

  hp_seq_fsm #(.W(NUM_SLOTS)) fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_reset   (sys_reset),
    .eject_go    (eject_wr),
    .eject_idx   (ej_idx),
    .pend_any    (pd_any),
    .pend_idx    (pd_idx),
    .agent_ack   (agent_ack),
    .agent_free  (agent_free),
    .busy        (busy),
    .agent_req   (agent_req),
    .slot_q      (agent_slot),
    .clr_pend    (clr_pend),
    .clr_present (clr_present),
    .rebuild     (rebuild)
  );

  // pending bit cleared by either the eject write or the drain step
  assign clr_idx = busy ? pd_idx : ej_idx;

  hp_read_mux #(.W(NUM_SLOTS)) rd_i (
    .rd_en   (rd_en),
    .addr    (reg_addr),
    .present (present_q),
    .hp_en   (hp_en_q),
    .pend    (down_q),
    .rdata   (reg_rdata)
  );

  always_comb begin
    present_n = rebuild ? occupied : present_q;
    hp_en_n   = rebuild ? ~fixed_mask : hp_en_q;
    down_n    = down_q;
    gpe_n     = 1'b0;
    if (clr_present) present_n[agent_slot] = 1'b0;
    if (clr_pend)    down_n[clr_idx] = 1'b0;
    if (evt_valid) begin
      if (evt_insert) begin
        present_n[evt_slot] = 1'b1;
        gpe_n = ~evt_cold;
      end else begin
        down_n[evt_slot] = 1'b1;
        gpe_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
      hp_en_q   <= '0;
      down_q    <= '0;
      gpe_hp    <= 1'b0;
    end else begin
      present_q <= present_n;
      hp_en_q   <= hp_en_n;
      down_q    <= down_n;
      gpe_hp    <= gpe_n;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int NUM_SLOTS = 32,
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_req,
  input logic                 reg_we,
  input logic                 reg_size32,
  input logic [3:0]           reg_addr,
  input logic [NUM_SLOTS-1:0] reg_wdata,
  input logic                 evt_valid,
  input logic [SW-1:0]        evt_slot,
  input logic                 evt_insert,
  input logic                 evt_cold,
  input logic                 gpe_hp,
  input logic                 agent_req,
  input logic [SW-1:0]        agent_slot,
  input logic                 agent_ack,
  input logic                 sys_reset,
  input logic                 busy,
  input logic [NUM_SLOTS-1:0] down_q
);
  // R5
  gpe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_hp |-> $past(evt_valid && (!evt_insert || !evt_cold)));

  // R4
  cold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_insert && evt_cold) |=> !gpe_hp);

  // R6
  down_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_insert) |=> down_q[$past(evt_slot)]);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agent_req && !agent_ack) |=> (agent_req && $stable(agent_slot)));

  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agent_req |-> busy);

  // R9
  zero_ej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sys_reset && reg_req && reg_we && reg_size32 &&
     reg_addr == 4'h8 && reg_wdata == '0) |=> !agent_req);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (.*);

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_we, reg_size32;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        evt_valid, evt_insert, evt_cold;
  logic [4:0]  evt_slot;
  logic        gpe_hp, agent_req, agent_ack, agent_free;
  logic [4:0]  agent_slot;
  logic [31:0] occupied, fixed_mask;
  logic        sys_reset, busy;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [31:0] m_present, m_en, m_down;
  int          m_st;       // 0 idle, 1 waiting on agent, 2 drain
  bit          m_drain;
  int          m_slot;
  bit          m_gpe;

  // agent behaviour
  logic [31:0] ag_free_mask;
  int          ag_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_size32(reg_size32),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_insert(evt_insert),
    .evt_cold(evt_cold), .gpe_hp(gpe_hp),
    .agent_req(agent_req), .agent_slot(agent_slot),
    .agent_ack(agent_ack), .agent_free(agent_free),
    .occupied(occupied), .fixed_mask(fixed_mask),
    .sys_reset(sys_reset), .busy(busy)
  );

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_present = '0; m_en = '0; m_down = '0;
      m_st = 2; m_drain = 0; m_slot = 0; m_gpe = 0;
    end else begin
      logic [31:0] base_p;
      base_p = m_present;
      m_gpe = 0;
      case (m_st)
        0: begin
          if (sys_reset) m_st = 2;
          else if (reg_req && reg_we && reg_size32 && reg_addr == 4'h8 &&
                   reg_wdata != 0) begin
            m_slot = lowest(reg_wdata);
            m_down[m_slot] = 1'b0;
            m_st = 1; m_drain = 0;
          end
        end
        1: begin
          if (agent_ack) begin
            if (agent_free) base_p[m_slot] = 1'b0;
            m_st = m_drain ? 2 : 0;
          end
        end
        default: begin
          if (m_down == 0) begin
            m_en = ~fixed_mask; base_p = occupied; m_st = 0; m_drain = 0;
          end else begin
            m_slot = lowest(m_down);
            m_down[m_slot] = 1'b0;
            m_st = 1; m_drain = 1;
          end
        end
      endcase
      if (evt_valid) begin
        if (evt_insert) begin
          base_p[evt_slot] = 1'b1;
          m_gpe = !evt_cold;
        end else begin
          m_down[evt_slot] = 1'b1;
          m_gpe = 1;
        end
      end
      m_present = base_p;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(gpe_hp == m_gpe, "R5/R6 gpe_hp", {31'd0, gpe_hp}, {31'd0, m_gpe});
      check(agent_req == (m_st == 1), "R7 agent_req", {31'd0, agent_req},
            {31'd0, (m_st == 1)});
      if (m_st == 1)
        check(agent_slot == m_slot[4:0], "R7/R10 agent_slot", {27'd0, agent_slot},
              m_slot);
      check(busy == (m_st != 0), "R10 busy", {31'd0, busy}, {31'd0, (m_st != 0)});
    end
  end

  // slot agent: acknowledges two cycles after it sees a request
  always @(negedge clk) begin
    if (!rst_n) begin
      agent_ack <= 0; agent_free <= 0; ag_cnt <= 0;
    end else if (agent_ack) begin
      agent_ack <= 0; ag_cnt <= 0;
    end else if (agent_req) begin
      if (ag_cnt == 2) begin
        agent_ack  <= 1;
        agent_free <= ag_free_mask[agent_slot];
      end else ag_cnt <= ag_cnt + 1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit s32 = 1);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_size32 = s32;
    @(negedge clk);
    reg_req = 0; reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input bit s32, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a; reg_size32 = s32;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
    reg_req = 0;
  endtask

  task automatic evt(input int slot, input bit ins, input bit cold);
    @(negedge clk);
    evt_valid = 1; evt_slot = slot[4:0]; evt_insert = ins; evt_cold = cold;
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; reg_req = 0; reg_we = 0; reg_size32 = 1; reg_addr = 0; reg_wdata = 0;
    evt_valid = 0; evt_slot = 0; evt_insert = 0; evt_cold = 0; sys_reset = 0;
    occupied = 32'h0000_0013; fixed_mask = 32'h0000_0002;
    ag_free_mask = 32'hFFFF_FDFF;  // slot 9 reports "not free"
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b1, "R11 busy in reset", {31'd0, busy}, 32'd1);
    rd(4'h0, 1, 32'h0, "R11 up in reset");
    rd(4'hC, 1, 32'h0, "R11 rmv in reset");
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    rd(4'h0, 1, 32'h0000_0011, "R11 up after release");
    rd(4'hC, 1, 32'hFFFF_FFFD, "R11 rmv after release");
    rd(4'h4, 1, 32'h0, "R11 down after release");

    // R4 cold insert, R5 hot insert
    evt(5, 1, 1);
    rd(4'h0, 1, m_present & m_en, "R4 cold insert up");
    check(m_present[5], "R4 model", {31'd0, m_present[5]}, 32'd1);
    evt(9, 1, 0);
    rd(4'h0, 1, 32'h0000_0231, "R5 hot insert up");

    // R6 removals
    evt(9, 0, 0); evt(4, 0, 0); evt(0, 0, 0);
    rd(4'h4, 1, 32'h0000_0211, "R6 down mask");
    rd(4'h0, 1, 32'h0000_0231, "R6 present unchanged");

    // R3 ignored writes
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h4, 32'h0); wr(4'hC, 32'h0);
    wr(4'h8, 32'h0000_0010, 0);
    rd(4'h0, 1, 32'h0000_0231, "R3 up unchanged");
    rd(4'h4, 1, 32'h0000_0211, "R3 down unchanged");
    rd(4'hC, 1, 32'hFFFF_FFFD, "R3 rmv unchanged");
    check(busy == 0, "R3 short write no eject", {31'd0, busy}, 32'd0);

    // R1/R2 read decoding
    rd(4'h0, 0, 32'h0, "R1 narrow read");
    rd(4'h8, 1, 32'h0, "R2 eject reads zero");
    rd(4'h2, 1, 32'h0, "R2 unused offset");

    // R9 zero eject
    wr(4'h8, 32'h0);
    check(busy == 0, "R9 zero eject", {31'd0, busy}, 32'd0);
    rd(4'h4, 1, 32'h0000_0211, "R9 down after zero eject");

    // R7/R8 eject lowest of bits 4 and 9 -> slot 4, freed
    wr(4'h8, 32'h0000_0210);
    wr(4'h8, 32'h0000_0200);  // R9 ignored while busy
    wait_idle();
    rd(4'h4, 1, 32'h0000_0201, "R7 down after eject");
    rd(4'h0, 1, 32'h0000_0221, "R8 freed slot cleared");

    // R8 slot 9 not free
    wr(4'h8, 32'h8000_0200);
    wait_idle();
    rd(4'h4, 1, 32'h0000_0001, "R8 down after eject 9");
    rd(4'h0, 1, 32'h0000_0221, "R8 slot 9 kept present");

    // R10 drain and rebuild
    evt(5, 0, 0); evt(12, 0, 0);
    occupied = 32'h0000_0302;
    @(negedge clk); sys_reset = 1;
    @(negedge clk); sys_reset = 0;
    wait_idle();
    rd(4'h4, 1, 32'h0, "R10 down drained");
    rd(4'h0, 1, 32'h0000_0300, "R10 up rebuilt");
    rd(4'hC, 1, 32'hFFFF_FFFD, "R10 rmv rebuilt");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule